// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block copies a run of bytes between a peripheral data port and memory so that the processor does not have to run an instruction for every byte. Software sets a source address, a destination address, a byte count, a direction and a bus-sharing mode, then pulses `start`. The engine waits for the peripheral to report ready and requests the system bus. Once the bus is granted, it drives the address and data buses itself. Each byte takes one read cycle at the source address, which captures the byte, and one write cycle at the destination address.

The mode input selects how the bus is shared. In hold mode the engine keeps its request raised from the first grant until the last byte has been written. If the peripheral is not ready between bytes, the engine waits and keeps the bus. In steal mode the engine lowers its request after every write, so processor accesses can run between single transfers. It then requests the bus again for the next byte.

A sticky completion flag reports the end of the block. The flag is cleared by the next accepted start.

Top module: `dma_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `bus_req`, `bus_drive`, `bus_we`, `done` and `busy` are all 0.
- R2: After a start with a nonzero count, `bus_req` is not raised while `periph_ready` is 0. Every rise of `bus_req` is preceded by a cycle in which `periph_ready` was 1.
- R3: `bus_drive` is 1 only while both `bus_req` and `bus_gnt` are 1, and `bus_we` is 1 only while `bus_drive` is 1.
- R4: Each byte is moved in two consecutive driven cycles. The first is a read (`bus_we`=0) at the current source address, which captures `bus_rdata`. The second is a write (`bus_we`=1) at the current destination address, with `bus_wdata` equal to the captured byte.
- R5: With `cfg_dir`=0 (port to memory), the source address stays fixed and the destination address rises by 1 after each byte. With `cfg_dir`=1 (memory to port), the source address rises by 1 and the destination address stays fixed. Exactly `cfg_len` bytes are written.
- R6: With `cfg_steal`=0 (hold mode), `bus_req` rises exactly once per block. After any write other than the last, `bus_req` stays 1.
- R7: With `cfg_steal`=1 (steal mode), `bus_req` is 0 in the cycle after every write, and rises exactly once per byte.
- R8: `done` goes to 1 in the cycle after the last write, with `bus_req` and `bus_drive` at 0. It stays 1 until the next accepted start, which clears it one cycle later. `busy` is 0 whenever `done` is 1.
- R9: A start with `cfg_len`=0 sets `done` one cycle later and never raises `bus_req`.
- R10: A start pulse while `busy` is 1 is ignored. The running block completes with its original addresses, count, direction and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src | input | AW | Source address, sampled at start |
| cfg_dst | input | AW | Destination address, sampled at start |
| cfg_len | input | CW | Byte count, sampled at start |
| cfg_dir | input | 1 | 0: port to memory, 1: memory to port |
| cfg_steal | input | 1 | 0: hold the bus for the block, 1: release after each byte |
| start | input | 1 | One-cycle start pulse, accepted only when idle |
| periph_ready | input | 1 | Peripheral ready status |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_drive | output | 1 | Engine drives address and data buses this cycle |
| bus_we | output | 1 | Write strobe (1) or read (0) while driving |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled at the end of a read cycle |
| done | output | 1 | Sticky completion flag |
| busy | output | 1 | Block in progress |

## Verification
A fault in the count register changes how many bytes reach the destination. The bench sees this when `done` rises, by comparing memory or the port log, including the byte just past the block. An address register that steps on the wrong side sends bytes to the wrong location or repeats the port address, which shows up in the same comparison. A mode latch or sequencer fault shows as the wrong number of request rises over the block, or as a request that stays held in steal mode. The checker flags this on the cycle after the offending write. A start accepted while busy corrupts the running block's result, which is detected at its completion.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_REQ  = 3'd2,
    ST_RD   = 3'd3,
    ST_WR   = 3'd4,
    ST_HOLD = 3'd5
  } dma_st_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          capture,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] len_i,
  input  logic          dir_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [DW-1:0] data_o,
  output logic          last_o
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          dir_q, dir_d;

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    cnt_d = cnt_q;
    dir_d = dir_q;
    dat_d = dat_q;
    if (load) begin
      src_d = src_i;
      dst_d = dst_i;
      cnt_d = len_i;
      dir_d = dir_i;
    end else if (step) begin
      cnt_d = cnt_q - CNT_ONE;
      if (dir_q) src_d = src_q + AW'(1);
      else       dst_d = dst_q + AW'(1);
    end
    if (capture) dat_d = rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      dir_q <= 1'b0;
      dat_q <= '0;
    end else begin
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      dat_q <= dat_d;
    end
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign data_o = dat_q;
  assign last_o = (cnt_q == CNT_ONE);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic len_zero,
  input  logic steal_i,
  input  logic ready,
  input  logic gnt,
  input  logic last,
  output logic load,
  output logic step,
  output logic capture,
  output logic rd_phase,
  output logic req,
  output logic drive,
  output logic we,
  output logic done,
  output logic busy,
  output logic steal_o
);
  dma_st_e st_q, st_d;
  logic    done_q, done_d;
  logic    steal_q, steal_d;

  always_comb begin
    st_d    = st_q;
    done_d  = done_q;
    steal_d = steal_q;
    load    = 1'b0;
    step    = 1'b0;
    capture = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        if (len_zero) begin
          done_d = 1'b1;
        end else begin
          load    = 1'b1;
          done_d  = 1'b0;
          steal_d = steal_i;
          st_d    = ST_ARM;
        end
      end
      ST_ARM:  if (ready) st_d = ST_REQ;
      ST_REQ:  if (gnt)   st_d = ST_RD;
      ST_RD: begin
        capture = 1'b1;
        st_d    = ST_WR;
      end
      ST_WR: begin
        step = 1'b1;
        if (last) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (steal_q) st_d = ST_ARM;
        else if (ready)       st_d = ST_RD;
        else                  st_d = ST_HOLD;
      end
      ST_HOLD: if (ready) st_d = ST_RD;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      done_q  <= 1'b0;
      steal_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      done_q  <= done_d;
      steal_q <= steal_d;
    end
  end

  assign req      = (st_q == ST_REQ) || (st_q == ST_RD) ||
                    (st_q == ST_WR)  || (st_q == ST_HOLD);
  assign drive    = (st_q == ST_RD) || (st_q == ST_WR);
  assign we       = (st_q == ST_WR);
  assign rd_phase = (st_q == ST_RD);
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign steal_o  = steal_q;
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_len,
  input  logic          cfg_dir,
  input  logic          cfg_steal,
  input  logic          start,
  input  logic          periph_ready,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_drive,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic          busy
);
  logic          rst_s1, rst_sn;
  logic          load, step, capture, rd_phase, last, steal_q;
  logic [AW-1:0] src_a, dst_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  dma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sn),
    .load    (load),
    .step    (step),
    .capture (capture),
    .src_i   (cfg_src),
    .dst_i   (cfg_dst),
    .len_i   (cfg_len),
    .dir_i   (cfg_dir),
    .rdata_i (bus_rdata),
    .src_o   (src_a),
    .dst_o   (dst_a),
    .data_o  (bus_wdata),
    .last_o  (last)
  );

  dma_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .start    (start),
    .len_zero (cfg_len == '0),
    .steal_i  (cfg_steal),
    .ready    (periph_ready),
    .gnt      (bus_gnt),
    .last     (last),
    .load     (load),
    .step     (step),
    .capture  (capture),
    .rd_phase (rd_phase),
    .req      (bus_req),
    .drive    (bus_drive),
    .we       (bus_we),
    .done     (done),
    .busy     (busy),
    .steal_o  (steal_q)
  );

  assign bus_addr = rd_phase ? src_a : dst_a;
endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_req,
  input logic bus_gnt,
  input logic bus_drive,
  input logic bus_we,
  input logic done,
  input logic busy,
  input logic periph_ready,
  input logic steal_q
);
  assert_drive_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (bus_req && bus_gnt));
  assert_we_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_drive);
  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && !bus_we) |=> bus_we);
  assert_req_after_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(periph_ready));
  assert_hold_keeps_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!steal_q && bus_we) |=> (bus_req || done));
  assert_steal_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (steal_q && bus_we) |=> !bus_req);
  assert_done_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!bus_req && !bus_drive));
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind dma_ctrl dma_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .bus_gnt      (bus_gnt),
  .bus_drive    (bus_drive),
  .bus_we       (bus_we),
  .done         (done),
  .busy         (busy),
  .periph_ready (periph_ready),
  .steal_q      (steal_q)
);

// File: tb/tb_dma_ctrl.sv
`timescale 1ns/1ps
module tb_dma_ctrl;
  localparam int AW = 8, DW = 8, CW = 8;
  localparam logic [7:0] PORT = 8'hF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [CW-1:0] cfg_len = '0;
  logic cfg_dir = 1'b0, cfg_steal = 1'b0, start = 1'b0;
  logic periph_ready = 1'b0, bus_gnt = 1'b0;
  logic bus_req, bus_drive, bus_we, done, busy;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  logic [7:0] mem [256];
  logic [7:0] plog [64];
  int   plog_n = 0;
  logic [7:0] port_ctr = 8'h00;
  logic prev_rd_port = 1'b0;
  logic prev_req = 1'b0;
  int   req_rises = 0;
  int   cyc = 0;
  int   rmode = 0;
  int   glat = 0;
  logic [3:0] gsh = '0;
  int   n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  dma_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_len(cfg_len), .cfg_dir(cfg_dir), .cfg_steal(cfg_steal),
    .start(start), .periph_ready(periph_ready), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_drive(bus_drive), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .busy(busy));

  assign bus_rdata = (bus_addr == PORT) ? port_ctr : mem[bus_addr];

  // bus, memory and peripheral model, evaluated away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (bus_drive && bus_we) begin
      if (bus_addr == PORT) begin
        if (plog_n < 64) plog[plog_n] = bus_wdata;
        plog_n = plog_n + 1;
      end else mem[bus_addr] = bus_wdata;
    end
    if (prev_rd_port) port_ctr = port_ctr + 8'd1;
    prev_rd_port = bus_drive && !bus_we && (bus_addr == PORT);
    if (bus_req && !prev_req) req_rises = req_rises + 1;
    prev_req = bus_req;
    if (!bus_req) gsh = '0;
    else gsh = {gsh[2:0], 1'b1};
    bus_gnt = gsh[glat];
    case (rmode)
      0: periph_ready = 1'b1;
      1: periph_ready = ((cyc * 7) % 5) != 0;
      default: periph_ready = 1'b0;
    endcase
  end

  task automatic check(input string req, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic init_mem(input int k);
    for (int a = 0; a < 256; a++) mem[a] = 8'(a * 7 + k);
    plog_n = 0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // one complete block, checked against arithmetic expectations
  task automatic run_block(input int len, input logic dir, input logic steal,
                           input int rm, input int gl, input int k);
    logic ok;
    logic [7:0] seed, src, dst;
    int bad;
    init_mem(k);
    seed = 8'(k * 11 + 3);
    port_ctr = seed;
    src = dir ? 8'(8'h40 + k) : PORT;
    dst = dir ? PORT : 8'(8'h20 + k);
    rmode = rm; glat = gl;
    @(negedge clk);
    cfg_src = src; cfg_dst = dst; cfg_len = 8'(len);
    cfg_dir = dir; cfg_steal = steal;
    req_rises = 0;
    pulse_start();
    check("R8 done cleared by start", done == 1'b0, done, 0);
    wait_done(ok);
    check("R8 done reached", ok, ok, 1);
    bad = 0;
    if (!dir) begin
      for (int i = 0; i < len; i++)
        if (mem[8'(dst + i)] != 8'(seed + i)) bad++;
      check("R5 boundary byte untouched",
            mem[8'(dst + len)] == 8'((32'(dst) + len) * 7 + k),
            mem[8'(dst + len)], 8'((32'(dst) + len) * 7 + k));
    end else begin
      for (int i = 0; i < len; i++)
        if (plog[i] != mem[8'(src + i)]) bad++;
      check("R5 port write count", plog_n == len, plog_n, len);
    end
    check("R4 bytes copied", bad == 0, bad, 0);
    if (steal) check("R7 one request per byte", req_rises == len, req_rises, len);
    else       check("R6 one request per block", req_rises == 1, req_rises, 1);
    @(negedge clk); @(negedge clk);
    check("R8 done sticky, idle", done && !busy && !bus_req, done, 1);
  endtask

  initial begin
    logic ok;
    #23;
    check("R1 reset outputs", {bus_req, bus_drive, bus_we, done, busy} == 5'b0,
          {bus_req, bus_drive, bus_we, done, busy}, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 outputs after reset", {bus_req, bus_drive, bus_we, done, busy} == 5'b0,
          {bus_req, bus_drive, bus_we, done, busy}, 0);

    // R9: zero count
    cfg_len = '0; req_rises = 0;
    pulse_start();
    check("R9 done on zero count", done == 1'b1, done, 1);
    repeat (5) @(negedge clk);
    check("R9 no request", req_rises == 0 && !bus_req, req_rises, 0);

    // R2: no request while peripheral not ready
    init_mem(1); rmode = 2; glat = 0;
    cfg_src = PORT; cfg_dst = 8'h30; cfg_len = 8'd3; cfg_dir = 1'b0; cfg_steal = 1'b0;
    req_rises = 0; port_ctr = 8'h90;
    pulse_start();
    repeat (10) @(negedge clk);
    check("R2 no request before ready", req_rises == 0 && busy, req_rises, 0);
    rmode = 0;
    wait_done(ok);
    check("R2 completes once ready", ok && mem[8'h32] == 8'h92, mem[8'h32], 8'h92);

    // sweep over count, direction, mode, ready pattern and grant latency
    for (int len = 1; len <= 6; len++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 2; s++)
          run_block(len, d[0], s[0], (len + d) % 2, (len + s) % 4, len * 4 + d * 2 + s);

    // R10: start while busy ignored
    init_mem(5); rmode = 1; glat = 2; port_ctr = 8'h10;
    @(negedge clk);
    cfg_src = PORT; cfg_dst = 8'h60; cfg_len = 8'd4; cfg_dir = 1'b0; cfg_steal = 1'b0;
    req_rises = 0;
    pulse_start();
    repeat (4) @(negedge clk);
    cfg_src = 8'h10; cfg_dst = PORT; cfg_len = 8'd2; cfg_dir = 1'b1; cfg_steal = 1'b1;
    pulse_start();
    wait_done(ok);
    check("R10 original block completes",
          ok && mem[8'h63] == 8'h13 && mem[8'h64] == 8'(8'h64 * 7 + 5) && plog_n == 0,
          mem[8'h63], 8'h13);
    check("R10 original mode kept", req_rises == 1, req_rises, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule